// File: doc/BRIEF.md
# Bus-Master DMA Control Registers

This block is the register front end of one bus-master DMA channel for a disk controller. Software reaches it through a byte-lane register window. The window holds a command byte at offset 0, a status byte at offset 2 and a 32-bit descriptor table base address at offsets 4 to 7. Accesses can be 1, 2 or 4 bytes wide at any byte offset.

The block turns transitions of the command start bit into one-cycle strobes for the descriptor walker. A rising start bit first loads the walker's current table pointer from the base register and then, if the channel is idle, sends a kick. A falling start bit sends a cancel. The walker reports completion back, and that completion decides whether the active status bit stays set. The disk device interrupt line passes straight to the host interrupt output, and a high level is also recorded in a sticky status bit. The descriptor walking and the data movement live in other blocks.

Top module: `busdma_ctl_regs`

## Requirements
- R1: A command write whose bit 0 (start) equals the stored start bit produces no kick pulse and no cancel pulse. It also leaves the active bit and the table pointer unchanged.
- R2: A command write that changes start from 1 to 0 pulses `cancelPulse` during the write cycle. Status bit 0 (active) reads 0 afterwards.
- R3: A command write that changes start from 0 to 1 loads `tablePtr` from the base register. If active was 0, it also pulses `kickPulse` during the write cycle, and active reads 1 afterwards. If active was already 1, no kick is sent.
- R4: The command register stores only bit 0 (start) and bit 3 (direction, also driven on `xferDir`). All other command bits read 0.
- R5: Base address writes change only the byte lanes covered by the access (offset 4 is bits 7:0, offset 7 is bits 31:24). Bits 1:0 of the base address always read 0.
- R6: A read returns the register image shifted right by the byte offset and masked to the access width. `regSize` encodes the width as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R7: `hostIrq` equals `devIrq` at both levels. While `devIrq` is high, status bit 2 (interrupt) is set. A falling `devIrq` leaves bit 2 unchanged.
- R8: Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit. Writing status bit 0 has no effect. If a set source for a bit is present in the same cycle as its clear, the set wins.
- R9: A `walkDone` cycle with `walkMore` high sets active. A `walkDone` cycle with `walkMore` low clears active. A command write that changes start in the same cycle takes priority over `walkDone`. `walkFail` sets status bit 1.
- R10: After reset, the command, status and base address registers read 0, `tablePtr` is 0 and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset of the access |
| regSize | input | 2 | Access width code |
| wrData | input | 32 | Write data, lowest byte at regAddr |
| rdData | output | 32 | Read data, combinational |
| kickPulse | output | 1 | Start the descriptor walker |
| cancelPulse | output | 1 | Abort the descriptor walker |
| tablePtr | output | 32 | Current descriptor table pointer |
| xferDir | output | 1 | Stored direction bit |
| walkDone | input | 1 | Walker finished a transfer |
| walkMore | input | 1 | With walkDone: more data pending, keep active |
| walkFail | input | 1 | Walker error, sets status error bit |
| devIrq | input | 1 | Device interrupt line |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
The interrupt bit has two sources that can land in the same cycle: a software write-one-to-clear and a high device line. The bench holds `devIrq` high through the very cycle in which it writes 0x04 to the status byte. It then expects bit 2 to still read 1, and to clear only on a second write once the line is low. The bench also covers active-bit ordering: a completion with more data pending sets active while start is 0, and the next rising start must then load the pointer without a kick.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  localparam int BASE_BYTES = 4;
  localparam int BASE_W     = BASE_BYTES * 8;
  localparam int WIN_BYTES  = 8;
  localparam int CMD_OFF    = 0;
  localparam int STAT_OFF   = 2;
  localparam int BASE_OFF   = 4;
  localparam int START_BIT  = 0;
  localparam int DIR_BIT    = 3;
  localparam int ACT_BIT    = 0;
  localparam int ERR_BIT    = 1;
  localparam int INT_BIT    = 2;
  localparam logic [7:0] CMD_KEEP = 8'h09;

  typedef struct packed {
    logic loadPtr;
  } dpStrobe_t;

  function automatic int accBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/busdma_ctl.sv
module busdma_ctl
  import busdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [7:0] cmdByte,
  input  logic       statWrEn,
  input  logic [7:0] statByte,
  input  logic       walkDone,
  input  logic       walkMore,
  input  logic       walkFail,
  input  logic       devIrq,
  output logic [7:0] cmdReg,
  output logic [7:0] statReg,
  output logic       kickPulse,
  output logic       cancelPulse,
  output dpStrobe_t  strobe
);
  logic startChg, goStart, goStop;
  logic actBit, errBit, intBit;

  always_comb begin
    startChg    = cmdWrEn && (cmdByte[START_BIT] != cmdReg[START_BIT]);
    goStart     = startChg && cmdByte[START_BIT];
    goStop      = startChg && !cmdByte[START_BIT];
    kickPulse   = goStart && !actBit;
    cancelPulse = goStop;
    strobe.loadPtr = goStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      actBit <= 1'b0;
      errBit <= 1'b0;
      intBit <= 1'b0;
    end else begin
      if (cmdWrEn) cmdReg <= cmdByte & CMD_KEEP;
      if (goStop)        actBit <= 1'b0;
      else if (goStart)  actBit <= 1'b1;
      else if (walkDone) actBit <= walkMore;
      if (walkFail)                          errBit <= 1'b1;
      else if (statWrEn && statByte[ERR_BIT]) errBit <= 1'b0;
      if (devIrq)                            intBit <= 1'b1;
      else if (statWrEn && statByte[INT_BIT]) intBit <= 1'b0;
    end
  end

  always_comb begin
    statReg = '0;
    statReg[ACT_BIT] = actBit;
    statReg[ERR_BIT] = errBit;
    statReg[INT_BIT] = intBit;
  end
endmodule

// File: rtl/busdma_dp.sv
module busdma_dp
  import busdma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [BASE_BYTES-1:0] laneEn,
  input  logic [BASE_W-1:0]     laneData,
  output logic [BASE_W-1:0]     baseAddr,
  output logic [BASE_W-1:0]     tablePtr
);
  logic [BASE_W-1:0] nextBase;

  always_comb begin
    nextBase = baseAddr;
    for (int i = 0; i < BASE_BYTES; i++)
      if (laneEn[i]) nextBase[i*8 +: 8] = laneData[i*8 +: 8];
    nextBase[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      tablePtr <= '0;
    end else begin
      baseAddr <= nextBase;
      if (strobe.loadPtr) tablePtr <= baseAddr;
    end
  end
endmodule

// File: rtl/busdma_ctl_regs.sv
module busdma_ctl_regs
  import busdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [1:0]  regSize,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        kickPulse,
  output logic        cancelPulse,
  output logic [31:0] tablePtr,
  output logic        xferDir,
  input  logic        walkDone,
  input  logic        walkMore,
  input  logic        walkFail,
  input  logic        devIrq,
  output logic        hostIrq
);
  logic [7:0]            cmdReg, statReg, cmdByte, statByte;
  logic                  cmdWrEn, statWrEn;
  logic [BASE_BYTES-1:0] baseLaneEn;
  logic [BASE_W-1:0]     baseLaneData, baseAddr;
  logic [WIN_BYTES*8-1:0] regImg;
  dpStrobe_t             strobe;

  function automatic logic laneHit(input int lane, input int off, input int n);
    return (lane >= off) && (lane < off + n);
  endfunction

  function automatic logic [7:0] lanePick(input int lane, input int off,
                                          input logic [31:0] d);
    return d[((lane - off) & 3) * 8 +: 8];
  endfunction

  always_comb begin
    int offI, nI;
    offI     = int'(regAddr);
    nI       = accBytes(regSize);
    cmdWrEn  = regWr && laneHit(CMD_OFF, offI, nI);
    cmdByte  = lanePick(CMD_OFF, offI, wrData);
    statWrEn = regWr && laneHit(STAT_OFF, offI, nI);
    statByte = lanePick(STAT_OFF, offI, wrData);
    for (int i = 0; i < BASE_BYTES; i++) begin
      baseLaneEn[i]         = regWr && laneHit(BASE_OFF + i, offI, nI);
      baseLaneData[i*8 +: 8] = lanePick(BASE_OFF + i, offI, wrData);
    end
  end

  busdma_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdByte(cmdByte),
    .statWrEn(statWrEn), .statByte(statByte),
    .walkDone(walkDone), .walkMore(walkMore), .walkFail(walkFail),
    .devIrq(devIrq),
    .cmdReg(cmdReg), .statReg(statReg),
    .kickPulse(kickPulse), .cancelPulse(cancelPulse),
    .strobe(strobe)
  );

  busdma_dp u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .laneEn(baseLaneEn), .laneData(baseLaneData),
    .baseAddr(baseAddr), .tablePtr(tablePtr)
  );

  assign regImg  = {baseAddr, 8'h00, statReg, 8'h00, cmdReg};
  assign xferDir = cmdReg[DIR_BIT];
  assign hostIrq = devIrq;

  always_comb begin
    int offI, nI;
    offI   = int'(regAddr);
    nI     = accBytes(regSize);
    rdData = '0;
    for (int k = 0; k < 4; k++)
      if (k < nI && offI + k < WIN_BYTES)
        rdData[k*8 +: 8] = regImg[(offI + k) * 8 +: 8];
  end
endmodule

// File: rtl/busdma_chk.sv
module busdma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic        kickPulse,
  input logic        cancelPulse,
  input logic [31:0] tablePtr,
  input logic        devIrq,
  input logic [7:0]  statReg
);
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (kickPulse || cancelPulse) |-> regWr); // R1
  AST_KICK_CANCEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(kickPulse && cancelPulse)); // R1
  AST_CANCEL_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |=> !statReg[0]); // R2
  AST_KICK_RAISES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    kickPulse |=> statReg[0]); // R3
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    tablePtr[1:0] == 2'b00); // R5
  AST_IRQ_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    devIrq |=> statReg[2]); // R7
endmodule

bind busdma_ctl_regs busdma_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr),
  .kickPulse(kickPulse), .cancelPulse(cancelPulse),
  .tablePtr(tablePtr), .devIrq(devIrq), .statReg(statReg)
);

// File: tb/tb_busdma_ctl_regs.sv
module tb_busdma_ctl_regs;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [1:0]  regSize = '0;
  logic [31:0] wrData = '0, rdData, tablePtr;
  logic        kickPulse, cancelPulse, xferDir, hostIrq;
  logic        walkDone = 1'b0, walkMore = 1'b0, walkFail = 1'b0, devIrq = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic sawKick, sawCancel;

  always #5 clk = ~clk;

  busdma_ctl_regs dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input int sz, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(off); regSize = 2'(sz); wrData = d;
    #2 sawKick = kickPulse; sawCancel = cancelPulse;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input int off, input int sz, output logic [31:0] d);
    regAddr = 3'(off); regSize = 2'(sz);
    #1 d = rdData;
  endtask

  task automatic walk(input logic m, input logic f, input logic done);
    @(negedge clk);
    walkDone = done; walkMore = m; walkFail = f;
    @(negedge clk);
    walkDone = 1'b0; walkMore = 1'b0; walkFail = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 1, v); check("R10 cmd", v, 0);
    rd(2, 0, v); check("R10 status", v, 0);
    rd(4, 2, v); check("R10 base", v, 0);
    check("R10 tablePtr", tablePtr, 0);
    check("R10 strobes", {kickPulse, cancelPulse, hostIrq}, 0);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(4, 2, 32'h12345677); rd(4, 2, v); check("R5 align", v, 32'h12345674);
    wr(5, 0, 32'h000000AB); rd(4, 2, v); check("R5 byte lane", v, 32'h1234AB74);
    wr(6, 1, 32'h0000BEEF); rd(4, 2, v); check("R5 half lane", v, 32'hBEEFAB74);
    wr(4, 0, 32'h000000FF); rd(4, 2, v); check("R5 low byte", v, 32'hBEEFABFC);
    rd(5, 0, v); check("R6 byte read", v, 32'h000000AB);
    rd(6, 1, v); check("R6 half read", v, 32'h0000BEEF);
    rd(4, 1, v); check("R6 half low", v, 32'h0000ABFC);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(0, 0, 32'hFF);
    check("R3 kick", sawKick, 1); check("R3 no cancel", sawCancel, 0);
    check("R3 ptr load", tablePtr, 32'hBEEFABFC);
    rd(2, 0, v); check("R3 active", v & 1, 1);
    rd(0, 0, v); check("R4 cmd mask", v, 32'h09);
    check("R4 dir out", xferDir, 1);
    wr(4, 2, 32'h00001000);
    wr(0, 0, 32'h09);
    check("R1 same start no kick", sawKick, 0); check("R1 same start no cancel", sawCancel, 0);
    check("R1 ptr kept", tablePtr, 32'hBEEFABFC);
    wr(0, 0, 32'h01);
    check("R1 no strobe", {sawKick, sawCancel}, 0);
    rd(0, 0, v); check("R4 dir cleared", v, 32'h01);
    wr(0, 0, 32'h00);
    check("R2 cancel", sawCancel, 1);
    rd(2, 0, v); check("R2 active clear", v & 1, 0);
    wr(0, 0, 32'h00);
    check("R1 repeated stop", sawCancel, 0);
  endtask

  task automatic t_walk();
    logic [31:0] v;
    wr(0, 0, 32'h01); check("R3 kick again", sawKick, 1);
    check("R3 ptr new base", tablePtr, 32'h00001000);
    walk(1, 0, 1); rd(2, 0, v); check("R9 more keeps active", v & 1, 1);
    walk(0, 0, 1); rd(2, 0, v); check("R9 done clears active", v & 1, 0);
    wr(0, 0, 32'h00); check("R2 cancel when idle", sawCancel, 1);
    walk(1, 0, 1); rd(2, 0, v); check("R9 more sets active", v & 1, 1);
    wr(4, 2, 32'h00002000);
    wr(0, 0, 32'h01);
    check("R3 no kick when active", sawKick, 0);
    check("R3 ptr loaded anyway", tablePtr, 32'h00002000);
    walk(0, 1, 0); rd(2, 0, v); check("R9 fail sets err", v, 32'h03);
    wr(2, 0, 32'h02); rd(2, 0, v); check("R8 clear err", v, 32'h01);
    wr(2, 0, 32'h01); rd(2, 0, v); check("R8 active read-only", v, 32'h01);
    wr(0, 0, 32'h00); rd(2, 0, v); check("R2 stop clears", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk); devIrq = 1'b1;
    #1 check("R7 host high", hostIrq, 1);
    @(negedge clk); rd(2, 0, v); check("R7 bit set", v, 32'h04);
    devIrq = 1'b0;
    #1 check("R7 host low", hostIrq, 0);
    @(negedge clk); rd(2, 0, v); check("R7 bit held", v, 32'h04);
    wr(2, 0, 32'h04); rd(2, 0, v); check("R8 clear int", v, 0);
    @(negedge clk);
    devIrq = 1'b1; regWr = 1'b1; regAddr = 3'd2; regSize = 2'd0; wrData = 32'h04;
    @(negedge clk);
    regWr = 1'b0; devIrq = 1'b0;
    rd(2, 0, v); check("R8 set beats clear", v, 32'h04);
    wr(2, 0, 32'h04); rd(2, 0, v); check("R8 clear after", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_base();
    t_cmd();
    t_walk();
    t_irq();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule